// File: doc/BRIEF.md
# Serial signed-digit online adder

The block adds two radix-2 signed-digit numbers that arrive one digit per clock, most significant digit first, and emits their sum as a signed-digit stream in the same encoding. It is meant as the node of a multi-level adder tree, where each level's output stream feeds the next level's input with no conversion in between. The sum is formed in two carry-free stages. The first stage splits each position's digit sum into a transfer digit for the next higher position and an interim digit. The choice depends only on the sign of the next lower position's digit sum. The second stage adds the incoming transfer to the interim digit. No carry ever travels across more than one position.

A caller raises `start_i` together with the first digit of a new operand pair, then supplies the remaining digits. Two zero digits follow the last real digit to flush the pipeline. The leading digit of the result, which carries twice the weight of the operands' leading digit, appears after the edge that samples the second input digit. This is one cycle ahead of the digit at the operands' own leading position, so a following tree level can start early. `valid_i` low stalls the block with all state held.

Top module: `sd_online_adder`

## Requirements
- R1: Each input digit is two bits: bit 0 carries weight +1 and bit 1 carries weight -1, so 01 is +1, 10 is -1, and both 00 and 11 are zero.
- R2: `sum_o` and `carry_o` use 01 for +1, 10 for -1 and 00 for zero, and never show 11.
- R3: With `start_i` on the first of N digit pairs, followed by two zero pairs, let k count the valid edges from 0, where edge 0 samples the first pair. The `sum_o` digits seen after edges 1 to N+1, weighted 2^N down to 2^0, add up to the sum of the two operands.
- R4: After edge 1 of an operand, `carry_o` equals `sum_o`. It is the result's leading digit of weight 2^N, one cycle before the digit of weight 2^(N-1) appears after edge 2.
- R5: A valid edge with `start_i` high drives both outputs to zero and discards all history from earlier digits, so a new operand is summed correctly even when the previous one was never flushed.
- R6: While `valid_i` is low, the outputs and all internal state hold.
- R7: An active-low asynchronous reset drives both outputs to 00 at once.
- R8: `carry_o` is the transfer part of the digit on `sum_o`: if `carry_o` is +1 then `sum_o` is not -1, and if `carry_o` is -1 then `sum_o` is not +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A digit pair is present this cycle |
| start_i | input | 1 | First digit pair of a new operand |
| a_i | input | 2 | Operand A digit |
| b_i | input | 2 | Operand B digit |
| sum_o | output | 2 | Sum digit stream |
| carry_o | output | 2 | Transfer into the emitted digit; the leading result digit after edge 1 |

## Verification
The stimulus includes operands made entirely of +1 digits and entirely of -1 digits. These drive the transfer into saturation in both signs and test the leading-digit path. It also includes pairs of opposite sign that cancel, and operands written with the 11 form of zero, which separate the two zero encodings. Alternating and sparse patterns put lone ±1 position sums next to lower positions of either sign, which exercises both branches of the transfer choice. Random operands cover the remaining mixtures. Directed runs insert stalls in the middle of an operand, start a new operand over an unflushed one, and assert reset in the middle of an operand.

// File: rtl/sd_add_pkg.sv
package sd_add_pkg;
  typedef logic [1:0]        sd_enc_t;   // bit1: -1 weight, bit0: +1 weight
  typedef logic signed [1:0] sd_val_t;   // digit value -1..1
  typedef logic signed [2:0] pos_sum_t;  // position sum -2..2

  function automatic sd_val_t sd_decode(sd_enc_t d);
    case (d)
      2'b01:   return 2'sd1;
      2'b10:   return -2'sd1;
      default: return 2'sd0;
    endcase
  endfunction

  function automatic sd_enc_t sd_encode(sd_val_t v);
    if (v == 2'sd1)       return 2'b01;
    else if (v == -2'sd1) return 2'b10;
    else                  return 2'b00;
  endfunction
endpackage

// File: rtl/sd_pos_sum.sv
module sd_pos_sum
  import sd_add_pkg::*;
(
  input  sd_enc_t  a_i,
  input  sd_enc_t  b_i,
  output pos_sum_t p_o
);
  assign p_o = pos_sum_t'(sd_decode(a_i)) + pos_sum_t'(sd_decode(b_i));
endmodule

// File: rtl/sd_split.sv
module sd_split
  import sd_add_pkg::*;
(
  input  pos_sum_t p_hi_i,   // sum at this position
  input  logic     lo_neg_i, // sum at next lower position is negative
  output sd_val_t  t_o,      // transfer to next higher position
  output sd_val_t  w_o       // interim digit
);
  // Pick t,w so the lower position's transfer (same sign as lo) cannot overflow
  always_comb begin
    t_o = 2'sd0;
    w_o = 2'sd0;
    case (p_hi_i)
      3'sd2:  begin t_o = 2'sd1;  w_o = 2'sd0; end
      -3'sd2: begin t_o = -2'sd1; w_o = 2'sd0; end
      3'sd1: begin
        if (lo_neg_i) begin t_o = 2'sd0; w_o = 2'sd1;  end
        else          begin t_o = 2'sd1; w_o = -2'sd1; end
      end
      -3'sd1: begin
        if (lo_neg_i) begin t_o = -2'sd1; w_o = 2'sd1;  end
        else          begin t_o = 2'sd0;  w_o = -2'sd1; end
      end
      default: begin t_o = 2'sd0; w_o = 2'sd0; end
    endcase
  end
endmodule

// File: rtl/sd_online_adder.sv
module sd_online_adder
  import sd_add_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       start_i,
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [1:0] sum_o,
  output logic [1:0] carry_o
);
  pos_sum_t p_new, p_q, p_hi;
  sd_val_t  w_q, w_prev, t_n, w_n, z_n;
  sd_enc_t  sum_q, carry_q;

  sd_pos_sum i_pos_sum (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p_new)
  );

  // start drops history of the previous operand
  assign p_hi   = start_i ? '0 : p_q;
  assign w_prev = start_i ? '0 : w_q;

  // stage 1: split the previous position using the sign of the newest one
  sd_split i_split (
    .p_hi_i   (p_hi),
    .lo_neg_i (p_new[2]),
    .t_o      (t_n),
    .w_o      (w_n)
  );

  // stage 2: interim digit one position up plus its incoming transfer
  assign z_n = w_prev + t_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q     <= '0;
      w_q     <= '0;
      sum_q   <= '0;
      carry_q <= '0;
    end else if (valid_i) begin
      p_q     <= p_new;
      w_q     <= w_n;
      sum_q   <= sd_encode(z_n);
      carry_q <= sd_encode(t_n);
    end
  end

  assign sum_o   = sum_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/sd_online_adder_chk.sv
module sd_online_adder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       start_i,
  input logic [1:0] sum_o,
  input logic [1:0] carry_o
);
  assert_sum_enc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o != 2'b11);

  assert_carry_enc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o != 2'b11);

  assert_start_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i) |=> (sum_o == 2'b00 && carry_o == 2'b00));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sum_o) && $stable(carry_o)));

  assert_pos_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o == 2'b01) |-> (sum_o != 2'b10));

  assert_neg_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o == 2'b10) |-> (sum_o != 2'b01));
endmodule

bind sd_online_adder sd_online_adder_chk i_chk (.*);

// File: tb/test_sd_online_adder.sv
`timescale 1ns/1ps
module test_sd_online_adder;
  localparam int N  = 8;
  localparam int NV = 6;
  localparam logic [2*N-1:0] TAB_A [NV] = '{16'h5555, 16'hAAAA, 16'h5555, 16'hFFFF, 16'h6666, 16'h4001};
  localparam logic [2*N-1:0] TAB_B [NV] = '{16'h5555, 16'hAAAA, 16'hAAAA, 16'h0000, 16'h5A5A, 16'hB3C2};

  logic clk_i = 1'b0;
  logic rst_ni, valid_i, start_i;
  logic [1:0] a_i, b_i, sum_o, carry_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sd_online_adder i_sd_online_adder (.*);

  function automatic int dig(logic [1:0] d);
    return int'(d[0]) - int'(d[1]);
  endfunction

  function automatic int opval(logic [2*N-1:0] v);
    int acc = 0;
    for (int i = 0; i < N; i++) acc = acc * 2 + dig(v[2*N-1-2*i -: 2]);
    return acc;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] a, logic [1:0] b, logic st);
    a_i = a; b_i = b; start_i = st; valid_i = 1'b1;
    @(posedge clk_i); #1;
  endtask

  // one operand pair; stall_at<0 means no stall; flush=0 stops after N digits
  task automatic run_op(logic [2*N-1:0] av, logic [2*N-1:0] bv, int stall_at, bit flush);
    int acc = 0;
    bit enc_ok = 1'b1;
    bit pair_ok = 1'b1;
    int last = flush ? N + 1 : N - 1;
    for (int k = 0; k <= last; k++) begin
      logic [1:0] da, db;
      if (k == stall_at) begin
        logic [1:0] hs, hc;
        hs = sum_o; hc = carry_o;
        valid_i = 1'b0; a_i = 2'b01; b_i = 2'b01; start_i = 1'b1;
        repeat (2) begin @(posedge clk_i); #1; end
        chk(sum_o == hs && carry_o == hc, "R6 stall hold", int'(sum_o), int'(hs));
      end
      da = (k < N) ? av[2*N-1-2*k -: 2] : 2'b00;
      db = (k < N) ? bv[2*N-1-2*k -: 2] : 2'b00;
      step(da, db, k == 0);
      if (sum_o == 2'b11 || carry_o == 2'b11) enc_ok = 1'b0;
      if ((carry_o == 2'b01 && sum_o == 2'b10) || (carry_o == 2'b10 && sum_o == 2'b01)) pair_ok = 1'b0;
      if (k == 1) chk(carry_o == sum_o, "R4 leading digit", dig(carry_o), dig(sum_o));
      if (k >= 1) acc = acc * 2 + dig(sum_o);
    end
    valid_i = 1'b0; start_i = 1'b0;
    if (flush) begin
      chk(acc == opval(av) + opval(bv), "R3 R1 sum value", acc, opval(av) + opval(bv));
      chk(enc_ok, "R2 output encoding", int'(enc_ok), 1);
      chk(pair_ok, "R8 transfer sign", int'(pair_ok), 1);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_run, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0;
    #12;
    chk(sum_o == 2'b00 && carry_o == 2'b00, "R7 reset state", int'(sum_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    for (int v = 0; v < NV; v++) run_op(TAB_A[v], TAB_B[v], -1, 1'b1);

    for (int r = 0; r < 40; r++) begin
      logic [2*N-1:0] av, bv;
      for (int i = 0; i < N; i++) begin
        av[2*i +: 2] = 2'($urandom);
        bv[2*i +: 2] = 2'($urandom);
      end
      run_op(av, bv, (r % 4 == 0) ? 3 : -1, 1'b1);
    end

    // R6: stall in the middle of saturated operands
    run_op(16'h5555, 16'h5595, 4, 1'b1);

    // R5: new operand over an unflushed one
    run_op(16'h5555, 16'h5555, -1, 1'b0);
    step(2'b10, 2'b10, 1'b1);
    chk(sum_o == 2'b00 && carry_o == 2'b00, "R5 start clears outputs", int'(sum_o), 0);
    valid_i = 1'b0; start_i = 1'b0;
    run_op(16'h0001, 16'h0000, -1, 1'b1);
    run_op(16'h5555, 16'hAAAA, -1, 1'b0);
    run_op(16'h9A65, 16'h1111, -1, 1'b1);

    // R7: asynchronous reset in the middle of an operand
    step(2'b01, 2'b01, 1'b1);
    step(2'b01, 2'b01, 1'b0);
    #1 rst_ni = 1'b0;
    #1;
    chk(sum_o == 2'b00 && carry_o == 2'b00, "R7 async reset", int'(carry_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    run_op(16'hAAAA, 16'h5500, -1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule